// File: doc/BRIEF.md
# Speculative Load Data Forwarding Gate

This block sits next to a 16-slot reorder buffer and decides, for every slot that holds a load, when the load's returned data may be passed on to the instructions that depend on it. It keeps its own record of every slot in flight: its kind, whether a branch has resolved, whether a memory address is known, whether load data has come back, and whether a misprediction or memory-access fault has been flagged. From that record it raises one registered forward-enable bit per slot.

Two release policies are available through a mode input. The safe policy lets a load forward only when it is the oldest slot in flight. The early policy lets a load forward as soon as nothing older can still redirect execution or alias it. That means every older branch has resolved, every older load and store has its address, and no older slot carries a fault flag. Age is measured from the head pointer, so the ordering stays correct when the slots wrap around. A squash input removes a slot and everything younger in one cycle.

Top module: `ldfwd_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, every `fwd_en_o` bit is 0 and the buffer holds no slots.
- R2: A load whose data has not returned never has its `fwd_en_o` bit set, in either mode. A data-return event aimed at a slot that is not a load is ignored.
- R3: With `mode_i` = 0 (safe), a load's `fwd_en_o` bit rises on the edge after a cycle in which the load is the head slot and its data has returned, and at no other time.
- R4: With `mode_i` = 1 (early), a load with data may forward only in a cycle where no older slot is a branch (kind 2) that is still unresolved.
- R5: With `mode_i` = 1, a load may forward only in a cycle where every older load (kind 1) and store (kind 3) has its address computed. The load's own address is not required.
- R6: With `mode_i` = 1, a load may not forward while any older slot carries a fault flag (misprediction or memory-access exception).
- R7: `fwd_en_o` is registered. It rises one clock after the condition holds, and once set it stays set, despite later mode changes or faults, until its slot retires or is squashed.
- R8: A squash naming a live slot clears that slot and every younger one, including their `fwd_en_o` bits, on the next edge, and the tail moves to that slot. In that cycle a dispatch and a retire are both ignored. A squash naming a slot that is not live is ignored.
- R9: Age is taken relative to the head pointer, so a slot with a lower index that was dispatched after the wrap is treated as younger.
- R10: Dispatch writes the next slot at the tail with kind 0 other, 1 load, 2 branch or 3 store. A dispatch while all 16 slots are live is ignored. A retire frees the head slot. Events aimed at slots that are not live are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Release policy: 0 safe (head only), 1 early |
| disp_valid_i | input | 1 | Dispatch a new slot at the tail |
| disp_kind_i | input | 2 | Kind of the dispatched slot (0 other, 1 load, 2 branch, 3 store) |
| retire_i | input | 1 | Retire the head slot |
| br_done_valid_i | input | 1 | A branch has resolved |
| br_done_idx_i | input | 4 | Slot of the resolved branch |
| addr_valid_i | input | 1 | A memory address has been computed |
| addr_idx_i | input | 4 | Slot whose address is now known |
| data_valid_i | input | 1 | Load data has returned |
| data_idx_i | input | 4 | Slot whose data returned |
| fault_valid_i | input | 1 | A misprediction or memory-access fault is flagged |
| fault_idx_i | input | 4 | Slot carrying the fault |
| squash_valid_i | input | 1 | Squash a slot and all younger slots |
| squash_idx_i | input | 4 | Oldest slot to squash |
| fwd_en_o | output | 16 | Per-slot forward enable |

## Verification
The assertions take the event indices as plain slot numbers and expect the design to ignore events, squashes and retires that target slots that are not live. They allow `mode_i` to change on any cycle, because each check looks at the mode of the cycle in which the release was decided. The stimulus therefore aims most events at live slots between head and tail, sends a fraction at arbitrary slots, toggles the mode freely and keeps squashes rare, so the buffer fills, wraps and drains many times. Directed sequences force the full-buffer, wrap-around and squash-collision cases that random traffic reaches only seldom.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;

   typedef enum logic [1:0] {
      KIND_OTHER  = 2'd0,
      KIND_LOAD   = 2'd1,
      KIND_BRANCH = 2'd2,
      KIND_STORE  = 2'd3
   } op_kind_e;

   localparam logic MODE_SAFE  = 1'b0;
   localparam logic MODE_EARLY = 1'b1;

   typedef struct packed {
      logic     valid;
      op_kind_e kind;
      logic     br_done;
      logic     addr_ok;
      logic     data_ok;
      logic     fault;
   } slot_t;

endpackage

// File: rtl/ldfwd_entry.sv
module ldfwd_entry
   import ldfwd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     alloc_i,
   input  op_kind_e kind_i,
   input  logic     kill_i,
   input  logic     br_done_i,
   input  logic     addr_i,
   input  logic     data_i,
   input  logic     fault_i,
   input  logic     fwd_set_i,
   output logic     valid_o,
   output logic     ready_o,
   output logic     blk_o,
   output logic     fwd_o
);

   slot_t slot_q;
   logic  fwd_q;
   logic  is_mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         fwd_q  <= 1'b0;
      end else if (kill_i) begin
         slot_q <= '0;
         fwd_q  <= 1'b0;
      end else if (alloc_i) begin
         slot_q       <= '0;
         slot_q.valid <= 1'b1;
         slot_q.kind  <= kind_i;
         fwd_q        <= 1'b0;
      end else if (slot_q.valid) begin
         slot_q.br_done <= slot_q.br_done | br_done_i;
         slot_q.addr_ok <= slot_q.addr_ok | addr_i;
         slot_q.data_ok <= slot_q.data_ok | (data_i && slot_q.kind == KIND_LOAD);
         slot_q.fault   <= slot_q.fault | fault_i;
         fwd_q          <= fwd_q | fwd_set_i;
      end
   end

   assign is_mem  = (slot_q.kind == KIND_LOAD) || (slot_q.kind == KIND_STORE);
   assign valid_o = slot_q.valid;
   assign ready_o = slot_q.valid && slot_q.kind == KIND_LOAD && slot_q.data_ok;
   assign blk_o   = slot_q.valid &&
                    ((slot_q.kind == KIND_BRANCH && !slot_q.br_done) ||
                     (is_mem && !slot_q.addr_ok) ||
                     slot_q.fault);
   assign fwd_o   = fwd_q;

endmodule

// File: rtl/ldfwd_age_scan.sv
module ldfwd_age_scan #(
   parameter int DEPTH    = 16,
   parameter bit LOG_SCAN = 1'b1,
   localparam int IW      = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] blk_i,
   input  logic [IW-1:0]    head_i,
   output logic [DEPTH-1:0] older_o
);

   logic [DEPTH-1:0] aged;
   logic [DEPTH-1:0] incl;

   // rotate the blocker vector into age order: position 0 is the head
   for (genvar k = 0; k < DEPTH; k++) begin : g_rot
      logic [IW-1:0] src;
      assign src     = IW'(k) + head_i;
      assign aged[k] = blk_i[src];
   end

   if (LOG_SCAN) begin : g_log
      logic [DEPTH-1:0] lvl [IW+1];
      always_comb begin
         lvl[0] = aged;
         for (int l = 0; l < IW; l++) begin
            for (int k = 0; k < DEPTH; k++) begin
               if (k >= (1 << l)) lvl[l+1][k] = lvl[l][k] | lvl[l][k - (1 << l)];
               else               lvl[l+1][k] = lvl[l][k];
            end
         end
      end
      assign incl = lvl[IW];
   end else begin : g_ripple
      always_comb begin
         logic acc;
         acc = 1'b0;
         for (int k = 0; k < DEPTH; k++) begin
            acc     = acc | aged[k];
            incl[k] = acc;
         end
      end
   end

   // map back: a slot sees the OR of all strictly older blockers
   for (genvar i = 0; i < DEPTH; i++) begin : g_back
      logic [IW-1:0] r;
      assign r          = IW'(i) - head_i;
      assign older_o[i] = (r == '0) ? 1'b0 : incl[r - IW'(1)];
   end

endmodule

// File: rtl/ldfwd_rob_ctrl.sv
module ldfwd_rob_ctrl #(
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_req_i,
   input  logic          retire_req_i,
   input  logic          squash_i,
   input  logic [IW-1:0] squash_idx_i,
   output logic          disp_ok_o,
   output logic          retire_ok_o,
   output logic [IW-1:0] head_o,
   output logic [IW-1:0] tail_o,
   output logic [CW-1:0] count_o
);

   logic [IW-1:0] sq_dist;

   assign sq_dist     = squash_idx_i - head_o;
   assign disp_ok_o   = disp_req_i && !squash_i && (count_o != CW'(DEPTH));
   assign retire_ok_o = retire_req_i && !squash_i && (count_o != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_o  <= '0;
         tail_o  <= '0;
         count_o <= '0;
      end else if (squash_i) begin
         tail_o  <= squash_idx_i;
         count_o <= CW'(sq_dist);
      end else begin
         head_o  <= head_o + IW'(retire_ok_o);
         tail_o  <= tail_o + IW'(disp_ok_o);
         count_o <= count_o + CW'(disp_ok_o) - CW'(retire_ok_o);
      end
   end

endmodule

// File: rtl/ldfwd_gate.sv
module ldfwd_gate
   import ldfwd_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter bit LOG_SCAN = 1'b1,
   localparam int IW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             disp_valid_i,
   input  logic [1:0]       disp_kind_i,
   input  logic             retire_i,
   input  logic             br_done_valid_i,
   input  logic [IW-1:0]    br_done_idx_i,
   input  logic             addr_valid_i,
   input  logic [IW-1:0]    addr_idx_i,
   input  logic             data_valid_i,
   input  logic [IW-1:0]    data_idx_i,
   input  logic             fault_valid_i,
   input  logic [IW-1:0]    fault_idx_i,
   input  logic             squash_valid_i,
   input  logic [IW-1:0]    squash_idx_i,
   output logic [DEPTH-1:0] fwd_en_o
);

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ldfwd_gate: DEPTH must be a power of two of at least 2");
   end

   logic [IW-1:0]    head;
   logic [IW-1:0]    tail;
   logic [CW-1:0]    count;
   logic             disp_ok;
   logic             retire_ok;
   logic             squash_ok;
   logic [IW-1:0]    sq_rel;
   logic [DEPTH-1:0] ent_valid;
   logic [DEPTH-1:0] ent_ready;
   logic [DEPTH-1:0] ent_blk;
   logic [DEPTH-1:0] ent_kill;
   logic [DEPTH-1:0] older_blk;
   logic [DEPTH-1:0] fwd_set;

   assign squash_ok = squash_valid_i && ent_valid[squash_idx_i];
   assign sq_rel    = squash_idx_i - head;

   ldfwd_rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .disp_req_i   (disp_valid_i),
      .retire_req_i (retire_i),
      .squash_i     (squash_ok),
      .squash_idx_i (squash_idx_i),
      .disp_ok_o    (disp_ok),
      .retire_ok_o  (retire_ok),
      .head_o       (head),
      .tail_o       (tail),
      .count_o      (count)
   );

   ldfwd_age_scan #(.DEPTH(DEPTH), .LOG_SCAN(LOG_SCAN)) u_scan (
      .blk_i   (ent_blk),
      .head_i  (head),
      .older_o (older_blk)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [IW-1:0] rel;
      logic          at_head;
      logic          gate;
      logic          alloc;

      assign rel         = IW'(i) - head;
      assign at_head     = (rel == '0);
      assign gate        = (mode_i == MODE_EARLY) ? !older_blk[i] : at_head;
      assign alloc       = disp_ok && (tail == IW'(i));
      assign ent_kill[i] = (retire_ok && at_head) ||
                           (squash_ok && ent_valid[i] && rel >= sq_rel);
      assign fwd_set[i]  = ent_ready[i] && gate;

      ldfwd_entry u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_i   (alloc),
         .kind_i    (op_kind_e'(disp_kind_i)),
         .kill_i    (ent_kill[i]),
         .br_done_i (br_done_valid_i && br_done_idx_i == IW'(i)),
         .addr_i    (addr_valid_i && addr_idx_i == IW'(i)),
         .data_i    (data_valid_i && data_idx_i == IW'(i)),
         .fault_i   (fault_valid_i && fault_idx_i == IW'(i)),
         .fwd_set_i (fwd_set[i]),
         .valid_o   (ent_valid[i]),
         .ready_o   (ent_ready[i]),
         .blk_o     (ent_blk[i]),
         .fwd_o     (fwd_en_o[i])
      );
   end

endmodule

// File: rtl/ldfwd_gate_chk.sv
module ldfwd_gate_chk #(
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_i,
   input logic [DEPTH-1:0] fwd_en_o,
   input logic [DEPTH-1:0] ent_valid,
   input logic [DEPTH-1:0] ent_ready,
   input logic [DEPTH-1:0] ent_kill,
   input logic [DEPTH-1:0] older_blk,
   input logic [IW-1:0]    head,
   input logic [CW-1:0]    count
);

   assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      assert_fwd_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_en_o[i] |-> ent_ready[i]);

      assert_fwd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (fwd_en_o[i] && !ent_kill[i]) |=> fwd_en_o[i]);

      assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ent_kill[i] |=> (!fwd_en_o[i] && !ent_valid[i]));

      assert_safe_head_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fwd_en_o[i]) |-> ($past(mode_i) || $past(head) == IW'(i)));

      assert_early_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(fwd_en_o[i]) && $past(mode_i)) |-> !$past(older_blk[i]));
   end

endmodule

bind ldfwd_gate ldfwd_gate_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .fwd_en_o  (fwd_en_o),
   .ent_valid (ent_valid),
   .ent_ready (ent_ready),
   .ent_kill  (ent_kill),
   .older_blk (older_blk),
   .head      (head),
   .count     (count)
);

// File: tb/ldfwd_gate_tb.sv
`timescale 1ns/1ps
module ldfwd_gate_tb;

   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n, mode, dv, ret, bv, av, tv, fv, sv;
   logic [1:0]    dk;
   logic [3:0]    bi, ai, ti, fi, si;
   logic [N-1:0]  fwd;

   always #2 clk = ~clk;

   ldfwd_gate u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .disp_valid_i(dv), .disp_kind_i(dk), .retire_i(ret),
      .br_done_valid_i(bv), .br_done_idx_i(bi),
      .addr_valid_i(av), .addr_idx_i(ai),
      .data_valid_i(tv), .data_idx_i(ti),
      .fault_valid_i(fv), .fault_idx_i(fi),
      .squash_valid_i(sv), .squash_idx_i(si),
      .fwd_en_o(fwd)
   );

   int errs = 0;
   int checks = 0;
   bit done = 0;

   // behavioural model of the slot record
   logic       mv [N];
   logic [1:0] mk [N];
   logic       mb [N], ma [N], md [N], mf [N], mw [N];
   int         mhead, mtail, mcnt;

   function automatic int rel(int i);
      return (i - mhead + N) % N;
   endfunction

   function automatic logic blocker(int j);
      return mv[j] && ((mk[j] == 2'd2 && !mb[j]) ||
                       ((mk[j] == 2'd1 || mk[j] == 2'd3) && !ma[j]) || mf[j]);
   endfunction

   function automatic logic [N-1:0] model_fwd();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = mw[i];
      return v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         mv[i] = 0; mk[i] = 0; mb[i] = 0; ma[i] = 0; md[i] = 0; mf[i] = 0; mw[i] = 0;
      end
      mhead = 0; mtail = 0; mcnt = 0;
   endtask

   task automatic model_step();
      logic [N-1:0] setv;
      logic sq_ok, r_ok, d_ok, older, gate, kill;
      int sr;
      for (int i = 0; i < N; i++) begin
         older = 0;
         for (int j = 0; j < N; j++)
            if (rel(j) < rel(i) && blocker(j)) older = 1;
         gate    = mode ? !older : (rel(i) == 0);
         setv[i] = mv[i] && mk[i] == 2'd1 && md[i] && gate;
      end
      sq_ok = sv && mv[si];
      sr    = rel(int'(si));
      r_ok  = ret && !sq_ok && mcnt > 0;
      d_ok  = dv && !sq_ok && mcnt < N;
      for (int i = 0; i < N; i++) begin
         if (mv[i]) begin
            kill = (r_ok && rel(i) == 0) || (sq_ok && rel(i) >= sr);
            if (kill) begin
               mv[i] = 0; mk[i] = 0; mb[i] = 0; ma[i] = 0; md[i] = 0; mf[i] = 0; mw[i] = 0;
            end else begin
               mb[i] = mb[i] | (bv && int'(bi) == i);
               ma[i] = ma[i] | (av && int'(ai) == i);
               md[i] = md[i] | (tv && int'(ti) == i && mk[i] == 2'd1);
               mf[i] = mf[i] | (fv && int'(fi) == i);
               mw[i] = mw[i] | setv[i];
            end
         end
      end
      if (d_ok) begin
         mv[mtail] = 1; mk[mtail] = dk;
         mb[mtail] = 0; ma[mtail] = 0; md[mtail] = 0; mf[mtail] = 0; mw[mtail] = 0;
      end
      if (sq_ok) begin
         mtail = int'(si); mcnt = sr;
      end else begin
         mhead = (mhead + int'(r_ok)) % N;
         mtail = (mtail + int'(d_ok)) % N;
         mcnt  = mcnt + int'(d_ok) - int'(r_ok);
      end
   endtask

   task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: fwd_en_o=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_in();
      dv = 0; dk = 0; ret = 0; bv = 0; bi = 0; av = 0; ai = 0;
      tv = 0; ti = 0; fv = 0; fi = 0; sv = 0; si = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic cyc_chk(string tag);
      cyc();
      chk(tag, fwd, model_fwd());
      idle_in();
   endtask

   task automatic do_reset();
      idle_in();
      rst_n = 0;
      model_reset();
      repeat (2) @(negedge clk);
      chk("R1 during reset", fwd, '0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset", fwd, '0);
   endtask

   // row = {mode, op[2:0], idx_or_kind[3:0], expected fwd_en_o[15:0]}
   // op: 0 idle, 1 dispatch, 2 retire, 3 resolve, 4 address, 5 data, 6 fault, 7 squash
   localparam int NROWS = 25;
   localparam logic [23:0] TBL [NROWS] = '{
      24'h91_0000, 24'h92_0000, 24'h91_0000, 24'hD2_0000, 24'h80_0000,
      24'hC0_0000, 24'h80_0000, 24'hB1_0000, 24'h80_0004, 24'h91_0004,
      24'hC2_0004, 24'hE1_0004, 24'hD3_0004, 24'h80_0004, 24'hF1_0000,
      24'h90_0000, 24'h80_0000, 24'h50_0000, 24'h00_0001, 24'h11_0001,
      24'h52_0001, 24'h00_0001, 24'h20_0000, 24'h20_0000, 24'h00_0004
   };

   function automatic string row_tag(int r);
      case (r)
         4:       return "R5 older load address pending";
         6:       return "R4 older branch unresolved";
         8:       return "R4 R5 release after resolve";
         13:      return "R6 R7 older fault blocks, earlier release sticky";
         14:      return "R8 squash clears younger";
         16:      return "R2 load without data";
         18, 24:  return "R3 head release";
         21:      return "R3 non-head held in safe mode";
         22:      return "R7 retire clears enable";
         default: return "R10 table row";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      mode = 0;
      do_reset();

      // table walk
      for (int r = 0; r < NROWS; r++) begin
         logic [23:0] v;
         v = TBL[r];
         idle_in();
         mode = v[23];
         case (v[22:20])
            3'd1: begin dv = 1; dk = v[17:16]; end
            3'd2: ret = 1;
            3'd3: begin bv = 1; bi = v[19:16]; end
            3'd4: begin av = 1; ai = v[19:16]; end
            3'd5: begin tv = 1; ti = v[19:16]; end
            3'd6: begin fv = 1; fi = v[19:16]; end
            3'd7: begin sv = 1; si = v[19:16]; end
            default: ;
         endcase
         cyc();
         chk(row_tag(r), fwd, v[15:0]);
      end

      // full buffer: extra dispatch must not overwrite slot 0
      do_reset();
      mode = 0;
      dv = 1; dk = 2'd1; cyc_chk("R10 dispatch load");
      tv = 1; ti = 4'd0; cyc_chk("R2 data return");
      cyc_chk("R3 head load released");
      chk("R3 slot 0 enable", {15'd0, fwd[0]}, 16'h0001);
      for (int k = 0; k < 15; k++) begin
         dv = 1; dk = 2'd0; cyc_chk("R10 fill");
      end
      dv = 1; dk = 2'd1; cyc_chk("R10 dispatch while full ignored");
      chk("R10 slot 0 kept", {15'd0, fwd[0]}, 16'h0001);

      // wrap-around
      for (int k = 0; k < 16; k++) begin
         ret = 1; cyc_chk("R7 drain");
      end
      for (int k = 0; k < 14; k++) begin
         dv = 1; dk = 2'd0; cyc_chk("R10 advance");
         ret = 1; cyc_chk("R10 advance retire");
      end
      mode = 1;
      dv = 1; dk = 2'd2; cyc_chk("R9 branch at slot 14");
      dv = 1; dk = 2'd1; cyc_chk("R9 load at slot 15");
      dv = 1; dk = 2'd1; cyc_chk("R9 load at slot 0");
      tv = 1; ti = 4'd15; cyc_chk("R9 data 15");
      tv = 1; ti = 4'd0; cyc_chk("R9 data 0");
      cyc_chk("R9 wrapped slots blocked");
      chk("R9 slot 0 younger than 14", fwd, 16'h0000);
      bv = 1; bi = 4'd14; cyc_chk("R9 resolve 14");
      av = 1; ai = 4'd15; cyc_chk("R9 address 15");
      cyc_chk("R9 wrapped release");
      chk("R9 slots 15 and 0 released", fwd, 16'h8001);

      // squash collision with dispatch and retire
      mode = 0;
      sv = 1; si = 4'd15; dv = 1; dk = 2'd1; ret = 1;
      cyc_chk("R8 squash wins over dispatch and retire");
      chk("R8 squashed enables cleared", fwd, 16'h0000);
      dv = 1; dk = 2'd1; cyc_chk("R8 redispatch at squash point");
      tv = 1; ti = 4'd15; cyc_chk("R8 data");
      cyc_chk("R8 retire was ignored, head still 14");
      ret = 1; cyc_chk("R3 retire branch");
      cyc_chk("R3 new head released");
      chk("R3 slot 15 released", fwd, 16'h8000);
      sv = 1; si = 4'd5; cyc_chk("R8 squash of dead slot ignored");
      chk("R8 enable kept", fwd, 16'h8000);

      // randomized traffic
      do_reset();
      for (int c = 0; c < 6000; c++) begin
         idle_in();
         mode = 1'($urandom_range(0, 1));
         dv   = ($urandom_range(0, 99) < 55);
         dk   = 2'($urandom_range(0, 3));
         ret  = ($urandom_range(0, 99) < 25);
         bv   = ($urandom_range(0, 99) < 40);
         av   = ($urandom_range(0, 99) < 40);
         tv   = ($urandom_range(0, 99) < 40);
         fv   = ($urandom_range(0, 99) < 4);
         sv   = ($urandom_range(0, 99) < 3);
         bi   = 4'((mhead + $urandom_range(0, 15)) % N);
         ai   = 4'((mhead + $urandom_range(0, (mcnt > 0) ? mcnt - 1 : 0)) % N);
         ti   = 4'((mhead + $urandom_range(0, (mcnt > 0) ? mcnt - 1 : 0)) % N);
         fi   = 4'((mhead + $urandom_range(0, (mcnt > 0) ? mcnt - 1 : 0)) % N);
         si   = 4'((mhead + $urandom_range(0, (mcnt > 0) ? mcnt : 0)) % N);
         cyc();
         chk("R2 R3 R4 R5 R6 R7 R8 R9 random traffic", fwd, model_fwd());
      end

      do_reset();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule